// File: doc/BRIEF.md
# Programmable Sequencing State Cell

This block evaluates one state of a table-driven power sequencing engine. A small register array holds one configuration word per state. The cell reads the word of the current state and watches a vector of logic inputs. It decides which of three exits leaves the state and moves to the next-state index that the word names for that exit.

The three exits are checked in a fixed order:

- **Monitor exit.** A masked compare of every input against an expected level. It has no delay.
- **Sequence exit.** One selected input, with optional polarity inversion or an unconditional force-flow option, gated by a programmable delay.
- **Timeout exit.** Fires when a programmable tick count is reached.

Delay and timeout are counted in pulses of an external 10 µs tick. Both counts restart at each state entry.

After reset, and after every transition, the cell spends a fixed number of clock cycles reloading the new state's word. During that time it evaluates nothing and flags itself busy. A host fills the table while reset is held, then releases reset and lets the cell run from state 0.

Top module: `seq_state_cell`

## Requirements
- R1: `state_o` is a registered state index. It resets to 0, takes the chosen exit's next-state index on the clock edge at which that exit fires, and holds at all other edges.
- R2: When more than one exit is true in the same evaluation cycle, the priority is monitor, then sequence, then timeout. `exit_o` marks the exit taken as a one-cycle one-hot pulse, aligned with the `state_o` update: bit 0 is monitor, bit 1 is sequence, bit 2 is timeout. Otherwise `exit_o` is zero.
- R3: The monitor exit fires when any input whose mask bit is 1 differs from its expected-level bit. Inputs with mask bit 0 are ignored. The monitor has no delay and fires in the first evaluation cycle in which the mismatch is present.
- R4: The sequence exit fires when the selected input (index `seq_sel`), after optional inversion, is 1 and the state's tick count is at least `seq_dly`.
- R5: With the invert bit set, the selected input must be 0 for the sequence exit to fire. A selected input of 1 then does not fire it.
- R6: With the force-flow bit set, the sequence exit fires once the tick count reaches `seq_dly`, whatever the inputs.
- R7: After reset release and after every transition, `busy_o` is high for exactly LOAD_CYC clock cycles. No exit fires while `busy_o` is high, and an exit is first possible in the cycle after it falls.
- R8: The timeout exit fires when the timeout value is non-zero and the tick count is at least that value. A value of 0 disables the timeout.
- R9: The delay and timeout counts advance by one for each clock cycle with `tick_i` high while the cell is not busy. They restart from zero at every transition and saturate at all ones.
- R10: `cfg_we_i` writes `cfg_data_i` into entry `cfg_addr_i` on a clock edge. Field layout with defaults (bit positions): force-flow [49], invert [48], `seq_sel` [47:45], `seq_dly` [44:35], mask [34:27], expected levels [26:19], timeout [18:9], sequence next [8:6], monitor next [5:3], timeout next [2:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration table write enable |
| cfg_addr_i | input | ST_W | Table entry to write |
| cfg_data_i | input | CFG_W | Configuration word |
| tick_i | input | 1 | Timebase pulse, one per 10 µs |
| in_i | input | N_IN | Monitored and sequence inputs |
| busy_o | output | 1 | Configuration load in progress |
| exit_o | output | 3 | One-hot exit taken (monitor, sequence, timeout) |
| state_o | output | ST_W | Current state index |

## Verification
The assertions take for granted that the table entry of the running state does not change while it is being evaluated, and that inputs and tick are synchronous to the clock. The stimulus respects this in two ways. It rewrites the table only while reset is held. It changes the inputs and the tick only on falling clock edges, with input bits flipping at a low rate so that the delayed exits are also reached. Directed runs cover each exit type, the priority order and the reload latency, with exact cycle counts from reset release or from the previous transition.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  localparam int EXIT_W   = 3;
  localparam int EXIT_MON = 0;
  localparam int EXIT_SEQ = 1;
  localparam int EXIT_TMO = 2;
  typedef logic [EXIT_W-1:0] exit_t;
endpackage

// File: rtl/ssc_cfg_store.sv
module ssc_cfg_store #(
  parameter int N_ST  = 8,
  parameter int CFG_W = 50,
  localparam int ST_W = $clog2(N_ST)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [ST_W-1:0]  waddr_i,
  input  logic [CFG_W-1:0] wdata_i,
  input  logic [ST_W-1:0]  raddr_i,
  output logic [CFG_W-1:0] rdata_o
);
  logic [CFG_W-1:0] mem_q [N_ST];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/ssc_tick_cnt.sv
module ssc_tick_cnt #(
  parameter int W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [W-1:0] limit_i,
  output logic         hit_o
);
  localparam logic [W-1:0] MAX = {W{1'b1}};
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clr_i)               cnt_q <= '0;
    else if (en_i && cnt_q != MAX) cnt_q <= cnt_q + W'(1);
  end

  assign hit_o = (cnt_q >= limit_i);

  p_cnt_sat_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && cnt_q == MAX) |=> cnt_q == MAX);
  p_cnt_restart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
  p_cnt_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !en_i) |=> $stable(cnt_q));
endmodule

// File: rtl/ssc_exit_eval.sv
module ssc_exit_eval
  import ssc_pkg::*;
#(
  parameter int N_IN  = 8,
  parameter int ST_W  = 3,
  localparam int SEL_W = $clog2(N_IN)
) (
  input  logic [N_IN-1:0]  in_i,
  input  logic [N_IN-1:0]  mask_i,
  input  logic [N_IN-1:0]  expv_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             inv_i,
  input  logic             ff_i,
  input  logic             dly_hit_i,
  input  logic             tmo_hit_i,
  input  logic             tmo_en_i,
  input  logic [ST_W-1:0]  nxt_seq_i,
  input  logic [ST_W-1:0]  nxt_mon_i,
  input  logic [ST_W-1:0]  nxt_tmo_i,
  output logic             mon_o,
  output logic             seq_o,
  output logic             tmo_o,
  output exit_t            fire_o,
  output logic [ST_W-1:0]  nxt_o
);
  // wide OR of mismatches against expected level
  assign mon_o = |((in_i ^ expv_i) & mask_i);
  assign seq_o = (ff_i | (in_i[sel_i] ^ inv_i)) & dly_hit_i;
  assign tmo_o = tmo_en_i & tmo_hit_i;

  always_comb begin
    fire_o = '0;
    nxt_o  = '0;
    if (mon_o) begin
      fire_o[EXIT_MON] = 1'b1;
      nxt_o            = nxt_mon_i;
    end else if (seq_o) begin
      fire_o[EXIT_SEQ] = 1'b1;
      nxt_o            = nxt_seq_i;
    end else if (tmo_o) begin
      fire_o[EXIT_TMO] = 1'b1;
      nxt_o            = nxt_tmo_i;
    end
  end
endmodule

// File: rtl/seq_state_cell.sv
module seq_state_cell
  import ssc_pkg::*;
#(
  parameter int N_ST     = 8,
  parameter int N_IN     = 8,
  parameter int DLY_W    = 10,
  parameter int TMO_W    = 10,
  parameter int LOAD_CYC = 4,
  localparam int ST_W  = $clog2(N_ST),
  localparam int SEL_W = $clog2(N_IN),
  localparam int CFG_W = 2 + SEL_W + DLY_W + 2 * N_IN + TMO_W + 3 * ST_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [ST_W-1:0]  cfg_addr_i,
  input  logic [CFG_W-1:0] cfg_data_i,
  input  logic             tick_i,
  input  logic [N_IN-1:0]  in_i,
  output logic             busy_o,
  output logic [2:0]       exit_o,
  output logic [ST_W-1:0]  state_o
);
  localparam int LD_W = $clog2(LOAD_CYC + 1);

  typedef struct packed {
    logic             ff;
    logic             inv;
    logic [SEL_W-1:0] sel;
    logic [DLY_W-1:0] dly;
    logic [N_IN-1:0]  mask;
    logic [N_IN-1:0]  expv;
    logic [TMO_W-1:0] tmo;
    logic [ST_W-1:0]  nxt_seq;
    logic [ST_W-1:0]  nxt_mon;
    logic [ST_W-1:0]  nxt_tmo;
  } cfg_t;

  logic [ST_W-1:0]  state_q;
  logic [LD_W-1:0]  load_q;
  exit_t            exit_q;
  logic [CFG_W-1:0] rdata;
  cfg_t             cur;
  logic             eval_en, dly_hit, tmo_hit, mon, seq, tmo;
  exit_t            fire_raw, fire;
  logic [ST_W-1:0]  nxt;

  ssc_cfg_store #(.N_ST(N_ST), .CFG_W(CFG_W)) u_store (
    .clk_i   (clk_i),
    .we_i    (cfg_we_i),
    .waddr_i (cfg_addr_i),
    .wdata_i (cfg_data_i),
    .raddr_i (state_q),
    .rdata_o (rdata)
  );

  assign cur     = cfg_t'(rdata);
  assign eval_en = (load_q == '0);

  ssc_tick_cnt #(.W(DLY_W)) u_dly_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (|fire),
    .en_i    (tick_i & eval_en),
    .limit_i (cur.dly),
    .hit_o   (dly_hit)
  );

  ssc_tick_cnt #(.W(TMO_W)) u_tmo_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (|fire),
    .en_i    (tick_i & eval_en),
    .limit_i (cur.tmo),
    .hit_o   (tmo_hit)
  );

  ssc_exit_eval #(.N_IN(N_IN), .ST_W(ST_W)) u_eval (
    .in_i      (in_i),
    .mask_i    (cur.mask),
    .expv_i    (cur.expv),
    .sel_i     (cur.sel),
    .inv_i     (cur.inv),
    .ff_i      (cur.ff),
    .dly_hit_i (dly_hit),
    .tmo_hit_i (tmo_hit),
    .tmo_en_i  (|cur.tmo),
    .nxt_seq_i (cur.nxt_seq),
    .nxt_mon_i (cur.nxt_mon),
    .nxt_tmo_i (cur.nxt_tmo),
    .mon_o     (mon),
    .seq_o     (seq),
    .tmo_o     (tmo),
    .fire_o    (fire_raw),
    .nxt_o     (nxt)
  );

  // nothing is evaluated while the new word loads
  assign fire = eval_en ? fire_raw : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= '0;
      load_q  <= LD_W'(LOAD_CYC);
      exit_q  <= '0;
    end else begin
      exit_q <= fire;
      if (|fire) begin
        state_q <= nxt;
        load_q  <= LD_W'(LOAD_CYC);
      end else if (load_q != '0) begin
        load_q <= load_q - LD_W'(1);
      end
    end
  end

  assign busy_o  = (load_q != '0);
  assign exit_o  = exit_q;
  assign state_o = state_q;

  p_exit_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(exit_o));
  p_seq_over_tmo_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !mon && seq) |=> exit_o[EXIT_SEQ]);
  p_mon_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && mon) |=> exit_o[EXIT_MON]);
  p_busy_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> exit_o == '0);
  p_exit_loads_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exit_o != '0) |-> busy_o);
  p_state_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exit_o == '0) |-> $stable(state_o));
endmodule

// File: tb/seq_state_cell_tb.sv
module seq_state_cell_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LOAD = 4;
  localparam int SAT  = 1023;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  waddr = '0;
  logic [49:0] wdata = '0;
  logic        tick = 1'b0;
  logic [7:0]  in_v = '0;
  logic        busy;
  logic [2:0]  ex;
  logic [2:0]  st;

  seq_state_cell u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .cfg_we_i   (we),
    .cfg_addr_i (waddr),
    .cfg_data_i (wdata),
    .tick_i     (tick),
    .in_i       (in_v),
    .busy_o     (busy),
    .exit_o     (ex),
    .state_o    (st)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [49:0] m_cfg [8];
  int          m_st, m_load, m_dly, m_tmo;
  logic [2:0]  m_exit;

  function automatic logic [49:0] mk_cfg(bit ff, bit inv, int sel, int dly,
      logic [7:0] mk, logic [7:0] xp, int tmo, int ns, int nm, int nt);
    return {ff, inv, 3'(sel), 10'(dly), mk, xp, 10'(tmo), 3'(ns), 3'(nm), 3'(nt)};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // reference model built from the requirements
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_load = LOAD; m_dly = 0; m_tmo = 0; m_exit = '0;
    end else begin
      m_exit = '0;
      if (m_load != 0) m_load--;
      else begin
        logic [49:0] w;
        bit flt, sq, to;
        int nx;
        w   = m_cfg[m_st];
        flt = |((in_v ^ w[26:19]) & w[34:27]);
        sq  = (w[49] || (in_v[w[47:45]] ^ w[48])) && (m_dly >= int'(w[44:35]));
        to  = (w[18:9] != 0) && (m_tmo >= int'(w[18:9]));
        nx  = -1;
        if (flt)     begin nx = int'(w[5:3]); m_exit = 3'b001; end
        else if (sq) begin nx = int'(w[8:6]); m_exit = 3'b010; end
        else if (to) begin nx = int'(w[2:0]); m_exit = 3'b100; end
        if (nx >= 0) begin
          m_st = nx; m_load = LOAD; m_dly = 0; m_tmo = 0;
        end else if (tick) begin
          if (m_dly < SAT) m_dly++;
          if (m_tmo < SAT) m_tmo++;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(busy == (m_load != 0), "R7 busy_o", busy, m_load != 0);
      chk(ex == m_exit, "R2 exit_o", ex, m_exit);
      chk(st == 3'(m_st), "R1 state_o", st, m_st);
    end
  end

  task automatic write_cfg(int a, logic [49:0] d);
    @(negedge clk);
    we = 1'b1; waddr = 3'(a); wdata = d; m_cfg[a] = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic wait_exit(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (ex == '0 && n < 300);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog expired act=1 exp=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'd4711));
    rst_n = 1'b0;
    in_v  = 8'b0010_0110;
    tick  = 1'b1;
    for (int s = 0; s < 8; s++) write_cfg(s, '0);
    write_cfg(0, mk_cfg(0, 0, 2, 3, 8'h00, 8'hFF, 0, 1, 0, 0));
    write_cfg(1, mk_cfg(0, 1, 5, 0, 8'h00, 8'h00, 6, 2, 0, 3));
    write_cfg(3, mk_cfg(1, 0, 0, 2, 8'h00, 8'h00, 0, 4, 0, 0));
    write_cfg(4, mk_cfg(0, 0, 1, 0, 8'h01, 8'h01, 1, 6, 5, 7));
    write_cfg(5, mk_cfg(0, 0, 7, 0, 8'h01, 8'h01, 0, 2, 0, 0));
    @(negedge clk);
    chk(busy == 1'b1, "R7 reset busy", busy, 1);
    chk(ex == 3'b000, "R2 reset exit", ex, 0);
    chk(st == 3'd0, "R1 reset state", st, 0);
    rst_n = 1'b1;

    // masked mismatches ignored, delayed sequence exit
    wait_exit(n);
    chk(n == LOAD + 4, "R4 R10 delay edges", n, LOAD + 4);
    chk(ex == 3'b010, "R3 R4 sequence exit", ex, 3'b010);
    chk(st == 3'd1, "R1 next state", st, 1);
    // inverted input at 1 blocks, timeout taken
    wait_exit(n);
    chk(n == LOAD + 7, "R8 R9 timeout edges", n, LOAD + 7);
    chk(ex == 3'b100, "R5 R8 timeout exit", ex, 3'b100);
    chk(st == 3'd3, "R1 timeout target", st, 3);
    // force flow
    wait_exit(n);
    chk(n == LOAD + 3, "R6 force edges", n, LOAD + 3);
    chk(ex == 3'b010, "R6 force exit", ex, 3'b010);
    chk(st == 3'd4, "R6 force target", st, 4);
    // monitor beats sequence
    wait_exit(n);
    chk(n == LOAD + 1, "R3 monitor edges", n, LOAD + 1);
    chk(ex == 3'b001, "R2 priority exit", ex, 3'b001);
    chk(st == 3'd5, "R2 priority target", st, 5);
    // fault present during load waits for load end
    wait_exit(n);
    chk(n == LOAD + 1, "R7 load latency", n, LOAD + 1);
    chk(ex == 3'b001, "R7 exit after load", ex, 3'b001);
    chk(st == 3'd0, "R1 back to 0", st, 0);

    for (int r = 0; r < 20; r++) begin
      @(negedge clk);
      rst_n = 1'b0;
      for (int s = 0; s < 8; s++)
        write_cfg(s, mk_cfg($urandom_range(0, 7) == 0, 1'($urandom_range(0, 1)),
                            $urandom_range(0, 7), $urandom_range(0, 6),
                            8'($urandom & $urandom & $urandom), 8'($urandom),
                            $urandom_range(0, 20), $urandom_range(0, 7),
                            $urandom_range(0, 7), $urandom_range(0, 7)));
      in_v = 8'($urandom);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2000) begin
        @(negedge clk);
        tick = 1'($urandom_range(0, 1));
        if ($urandom_range(0, 15) == 0) in_v[$urandom_range(0, 7)] ^= 1'b1;
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule